// File: doc/BRIEF.md
# Four-Mode Universal Shift Register

This block is a small parallel/serial register of `WIDTH` stages (4 by default). On each rising clock edge a two-bit mode code decides what the register does: keep its contents, shift toward the high-index stage, shift toward the low-index stage, or capture the parallel data bus. Each shift direction has its own serial input, so the same register can act as a serial-in/parallel-out converter, a parallel-in/serial-out converter, a bidirectional shifter or a plain storage register.

An active-low asynchronous clear forces every stage to 0 at once, with no clock edge needed. The clear wins over any mode for as long as it is held low. Rotations, ring counters and twisted-ring counters are not built in. A user builds them outside the block by wiring stage outputs back to the serial inputs.

Top module: `shreg_universal`

## Requirements
- R1: The register holds `WIDTH` stages. `par_i[i]` is the load value for stage i, and `q_o[i]` shows stage i at all times.
- R2: A low level on `rst_ni` sets `q_o` to all zeros immediately, with no clock edge.
- R3: While `rst_ni` is low, `q_o` stays all zeros whatever the mode, data and serial inputs are, across any number of clock edges.
- R4: With `mode_i` = 2'b11 (load), `q_o` equals the `par_i` sampled at the rising edge.
- R5: With `mode_i` = 2'b01 (right shift), each stage i>0 takes the old value of stage i-1. Stage 0 takes `ser_right_i`, and the old top stage is dropped.
- R6: With `mode_i` = 2'b10 (left shift), each stage i<WIDTH-1 takes the old value of stage i+1. The top stage takes `ser_left_i`, and the old stage 0 is dropped.
- R7: With `mode_i` = 2'b00 (hold), `q_o` keeps its value at each edge, whatever `par_i` and the serial inputs are.
- R8: The serial input of the unused direction has no effect. `ser_left_i` is ignored during a right shift, `ser_right_i` is ignored during a left shift, and `par_i` is ignored during both shifts.
- R9: With `rst_ni` high, `q_o` changes only at a rising clock edge. Changes to the inputs between edges leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all modes act on the rising edge |
| rst_ni | input | 1 | Active-low asynchronous clear of all stages |
| mode_i | input | 2 | 00 hold, 01 right shift, 10 left shift, 11 parallel load |
| par_i | input | WIDTH | Parallel load data, bit i to stage i |
| ser_right_i | input | 1 | Serial input entering stage 0 on right shift |
| ser_left_i | input | 1 | Serial input entering the top stage on left shift |
| q_o | output | WIDTH | Parallel outputs, bit i is stage i |

## Verification
The bench runs shift sequences that push a 1 through the end stages in both directions. It would catch a design that swaps the two serial inputs or reverses the direction, because the wrong end would fill. It drives the unused serial input and the data bus opposite to the expected result during shifts and holds, so a mux that leaks them shows up at `q_o`. It drops the clear between edges and keeps it low while load is selected, which exposes a clear that waits for the clock or loses to the load. It also changes the inputs mid-cycle, which would show a register that follows its inputs without a clock edge.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'b00,
    MODE_RIGHT = 2'b01,
    MODE_LEFT  = 2'b10,
    MODE_LOAD  = 2'b11
  } mode_e;

  typedef struct packed {
    logic hold;
    logic right;
    logic left;
    logic load;
  } sel_t;
endpackage

// File: rtl/shreg_mode_dec.sv
module shreg_mode_dec
  import shreg_pkg::*;
(
  input  logic [1:0] mode_i,
  output sel_t       sel_o
);
  always_comb begin
    sel_o = '0;
    unique case (mode_e'(mode_i))
      MODE_HOLD:  sel_o.hold  = 1'b1;
      MODE_RIGHT: sel_o.right = 1'b1;
      MODE_LEFT:  sel_o.left  = 1'b1;
      MODE_LOAD:  sel_o.load  = 1'b1;
      default:    sel_o.hold  = 1'b1;
    endcase
  end
endmodule

// File: rtl/shreg_next.sv
module shreg_next
  import shreg_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  sel_t             sel_i,
  input  logic [WIDTH-1:0] cur_i,
  input  logic [WIDTH-1:0] par_i,
  input  logic             ser_right_i,
  input  logic             ser_left_i,
  output logic [WIDTH-1:0] nxt_o
);
  localparam int TOP = WIDTH - 1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic from_low, from_high;
    if (i == 0) begin : g_low_end
      assign from_low = ser_right_i;
    end else begin : g_low_mid
      assign from_low = cur_i[i-1];
    end
    if (i == TOP) begin : g_high_end
      assign from_high = ser_left_i;
    end else begin : g_high_mid
      assign from_high = cur_i[i+1];
    end
    always_comb begin
      nxt_o[i] = cur_i[i];
      if (sel_i.load)       nxt_o[i] = par_i[i];
      else if (sel_i.right) nxt_o[i] = from_low;
      else if (sel_i.left)  nxt_o[i] = from_high;
    end
  end
endmodule

// File: rtl/shreg_universal.sv
module shreg_universal
  import shreg_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic [WIDTH-1:0] par_i,
  input  logic             ser_right_i,
  input  logic             ser_left_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int TOP = WIDTH - 1;

  sel_t             sel;
  logic [WIDTH-1:0] q_d, q_q;

  shreg_mode_dec u_dec (
    .mode_i (mode_i),
    .sel_o  (sel)
  );

  shreg_next #(.WIDTH(WIDTH)) u_next (
    .sel_i       (sel),
    .cur_i       (q_q),
    .par_i       (par_i),
    .ser_right_i (ser_right_i),
    .ser_left_i  (ser_left_i),
    .nxt_o       (q_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;

  p_clear_hold_r3: assert property (@(posedge clk_i)
    !rst_ni |-> q_q == '0);

  p_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b11 |=> q_q == $past(par_i));

  p_right_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b01 |=> q_q == {$past(q_q[TOP-1:0]), $past(ser_right_i)});

  p_left_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b10 |=> q_q == {$past(ser_left_i), $past(q_q[TOP:1])});

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b00 |=> $stable(q_q));
endmodule

// File: tb/shreg_universal_bench.sv
module shreg_universal_bench;
  localparam int W = 4;
  localparam int NV = 12;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b1;
  logic [1:0]   mode = 2'b00;
  logic [W-1:0] par = '0;
  logic         sr = 1'b0, sl = 1'b0;
  logic [W-1:0] q;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  shreg_universal #(.WIDTH(W)) u_shreg_universal (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .par_i(par),
    .ser_right_i(sr), .ser_left_i(sl), .q_o(q)
  );

  // {mode, par, ser_right, ser_left, expected q}
  localparam logic [11:0] VEC [NV] = '{
    {2'b11, 4'b1010, 1'b0, 1'b1, 4'b1010},  // R4 load
    {2'b01, 4'b1111, 1'b1, 1'b0, 4'b0101},  // R5 right, 1 in
    {2'b01, 4'b0101, 1'b0, 1'b1, 4'b1010},  // R5 R8 right, 0 in
    {2'b00, 4'b0101, 1'b1, 1'b1, 4'b1010},  // R7 hold
    {2'b10, 4'b0000, 1'b0, 1'b1, 4'b1101},  // R6 left, 1 in
    {2'b10, 4'b1111, 1'b1, 1'b0, 4'b0110},  // R6 R8 left, 0 in
    {2'b01, 4'b0011, 1'b0, 1'b1, 4'b1100},  // R5 R8
    {2'b11, 4'b0011, 1'b1, 1'b1, 4'b0011},  // R4 load
    {2'b00, 4'b1100, 1'b1, 1'b1, 4'b0011},  // R7 hold
    {2'b10, 4'b1111, 1'b1, 1'b0, 4'b0001},  // R6
    {2'b10, 4'b1111, 1'b1, 1'b0, 4'b0000},  // R6
    {2'b01, 4'b0000, 1'b1, 1'b1, 4'b0001}   // R5
  };

  task automatic check(input string req, input logic [W-1:0] exp);
    checks++;
    if (q !== exp) begin
      failures++;
      $display("FAIL %s q=%b expected=%b", req, q, exp);
    end
  endtask

  task automatic step(input logic [1:0] m, input logic [W-1:0] p,
                      input logic s_r, input logic s_l);
    @(negedge clk);
    mode = m; par = p; sr = s_r; sl = s_l;
    @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1 rst_ni = 1'b0;
    repeat (2) @(posedge clk);
    #1 check("R2 reset", '0);
    @(negedge clk) rst_ni = 1'b1;

    for (int k = 0; k < NV; k++) begin
      string tag;
      step(VEC[k][11:10], VEC[k][9:6], VEC[k][5], VEC[k][4]);
      case (VEC[k][11:10])
        2'b00:   tag = "R7 hold";
        2'b01:   tag = "R5 R8 right";
        2'b10:   tag = "R6 R8 left";
        default: tag = "R4 R1 load";
      endcase
      check(tag, VEC[k][3:0]);
    end

    // R9: mid-cycle input change has no effect before the edge
    step(2'b11, 4'b1001, 1'b0, 1'b0);
    check("R4 load 1001", 4'b1001);
    @(negedge clk);
    mode = 2'b11; par = 4'b0110;
    #1 check("R9 no change before edge", 4'b1001);
    @(posedge clk); #1 check("R9 update at edge", 4'b0110);

    // R2: asynchronous clear between edges
    step(2'b11, 4'b1111, 1'b1, 1'b1);
    check("R4 load ones", 4'b1111);
    #0.5 rst_ni = 1'b0;
    #0.5 check("R2 async clear", '0);

    // R3: clear beats load over several edges
    mode = 2'b11; par = 4'b1111;
    repeat (3) @(posedge clk);
    #1 check("R3 clear priority", '0);
    @(negedge clk) rst_ni = 1'b1;
    @(posedge clk); #1 check("R4 load after clear", 4'b1111);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule